// File: doc/BRIEF.md
# Halfword-Granular Unaligned Fetch Memory

This block is a read memory for instruction fetch in a processor whose program mixes 16-bit and 32-bit instructions. A 32-bit instruction may start on any 16-bit boundary. The read address therefore counts halfwords, and one read returns a full 32-bit word from any halfword position in a single access, whether that position is even or odd.

Storage is split into two 16-bit-wide banks. One bank holds the even halfwords and the other holds the odd halfwords. On an even start address, both banks read the same row. On an odd start address, the odd bank reads row k and the even bank reads row k+1. The two bank outputs are then swapped into place so that the result is little-endian. A size input asks for only 16 bits, for the case where the fetch unit already holds the lower part of a pair. A 16-bit write port lets the memory be filled before use.

Top module: `hwf_fetch_mem`

## Requirements
- R1: A read issued with `rd_en`=1 at any halfword address, even or odd, returns its data on `rd_data` in the following cycle, from a single access.
- R2: In 32-bit mode (`rd_size`=1), `rd_data[15:0]` is the halfword at `rd_addr` and `rd_data[31:16]` is the halfword at `rd_addr`+1.
- R3: A 32-bit read at the last halfword address (DEPTH_HW-1) takes its upper half from halfword 0.
- R4: In 16-bit mode (`rd_size`=0), `rd_data[15:0]` is the halfword at `rd_addr` and `rd_data[31:16]` is zero.
- R5: `rd_valid` is 1 in exactly those cycles that follow a cycle with `rd_en`=1.
- R6: After a cycle with `rd_en`=0, `rd_data` keeps the value it had before that cycle.
- R7: `wr_en`=1 stores `wr_data` at halfword `wr_addr`, and any read issued in a later cycle sees the stored value.
- R8: A read and a write to the same halfword in the same cycle return the value held before the write.
- R9: While `rst` is high, and in the first cycle after it falls, `rd_valid` is 0 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Start a read this cycle |
| rd_addr | input | AW = log2(DEPTH_HW) | Halfword start address of the read |
| rd_size | input | 1 | 1: 32-bit read, 0: 16-bit read |
| rd_data | output | 32 | Read result, little-endian halfword order |
| rd_valid | output | 1 | `rd_data` holds the result of the previous cycle's read |
| wr_en | input | 1 | Write one halfword this cycle |
| wr_addr | input | AW | Halfword address of the write |
| wr_data | input | 16 | Halfword to store |

## Verification
The hardest case to reach from the ports is the odd start address where the even bank's row must move forward by one. The hardest form of it is the wrap at the very last halfword, where that row increment overflows back to row 0. A random mix of addresses rarely lands there. The bench therefore drives the last address, and odd addresses next to row boundaries, directly with distinct preloaded data, so that a wrong row or a wrong lane order shows up as a value mismatch. Read-and-write collisions on the same halfword are also forced directly, and the random phase then mixes reads, writes and idle cycles against a bench model of the contents.

// File: rtl/hwf_pkg.sv
package hwf_pkg;

    localparam int HW_W   = 16;
    localparam int WORD_W = 2 * HW_W;

    typedef enum logic {
        SZ_HALF = 1'b0,
        SZ_WORD = 1'b1
    } fetch_size_e;

    typedef struct packed {
        logic [HW_W-1:0] hi;
        logic [HW_W-1:0] lo;
    } fetch_word_t;

    // Orders two bank outputs into a little-endian word and trims for size.
    function automatic fetch_word_t order_lanes(
        input logic [HW_W-1:0] even_hw,
        input logic [HW_W-1:0] odd_hw,
        input logic            odd_start,
        input fetch_size_e     size
    );
        fetch_word_t w;
        w.lo = odd_start ? odd_hw  : even_hw;
        w.hi = odd_start ? even_hw : odd_hw;
        if (size == SZ_HALF) begin
            w.hi = '0;
        end
        return w;
    endfunction

endpackage

// File: rtl/hwf_addr_split.sv
module hwf_addr_split #(
    parameter int AW = 8,
    localparam int RW = AW - 1
) (
    input  logic [AW-1:0] hw_addr,
    output logic [RW-1:0] even_row,
    output logic [RW-1:0] odd_row,
    output logic          odd_start
);
    logic [RW-1:0] base_row;

    always_comb begin
        base_row  = hw_addr[AW-1:1];
        odd_start = hw_addr[0];
        odd_row   = base_row;
        // Odd start: the second halfword lives in the next even row; the
        // increment wraps to row 0 at the top of the array.
        even_row  = odd_start ? RW'(base_row + 1'b1) : base_row;
    end
endmodule

// File: rtl/hwf_bank.sv
module hwf_bank #(
    parameter int RW = 7,
    parameter int DW = 16,
    localparam int ROWS = 1 << RW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [RW-1:0] rd_row,
    output logic [DW-1:0] rd_q,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [DW-1:0] wr_d
);
    logic [DW-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_row] <= wr_d;
        end
    end

    // Read register: old contents on a same-row write, holds when idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= cells[rd_row];
        end
    end
endmodule

// File: rtl/hwf_steer.sv
module hwf_steer
    import hwf_pkg::*;
(
    input  logic [HW_W-1:0]   even_q,
    input  logic [HW_W-1:0]   odd_q,
    input  logic              odd_start_q,
    input  fetch_size_e       size_q,
    output logic [WORD_W-1:0] word
);
    fetch_word_t w;

    always_comb begin
        w    = order_lanes(even_q, odd_q, odd_start_q, size_q);
        word = w;
    end
endmodule

// File: rtl/hwf_fetch_mem.sv
module hwf_fetch_mem
    import hwf_pkg::*;
#(
    parameter int DEPTH_HW = 256,
    localparam int AW = $clog2(DEPTH_HW),
    localparam int RW = AW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_size,
    output logic [31:0]   rd_data,
    output logic          rd_valid,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data
);
    logic [RW-1:0]   even_row;
    logic [RW-1:0]   odd_row;
    logic            odd_start;
    logic [RW-1:0]   bank_rd_row [2];
    logic [HW_W-1:0] bank_q      [2];
    logic            odd_start_q;
    fetch_size_e     size_q;
    logic            valid_q;

    hwf_addr_split #(.AW(AW)) u_split (
        .hw_addr   (rd_addr),
        .even_row  (even_row),
        .odd_row   (odd_row),
        .odd_start (odd_start)
    );

    assign bank_rd_row[0] = even_row;
    assign bank_rd_row[1] = odd_row;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        hwf_bank #(.RW(RW), .DW(HW_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .rd_en  (rd_en),
            .rd_row (bank_rd_row[b]),
            .rd_q   (bank_q[b]),
            .wr_en  (wr_en && (wr_addr[0] == 1'(b))),
            .wr_row (wr_addr[AW-1:1]),
            .wr_d   (wr_data)
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            odd_start_q <= 1'b0;
            size_q      <= SZ_HALF;
            valid_q     <= 1'b0;
        end else begin
            valid_q <= rd_en;
            if (rd_en) begin
                odd_start_q <= odd_start;
                size_q      <= fetch_size_e'(rd_size);
            end
        end
    end

    hwf_steer u_steer (
        .even_q      (bank_q[0]),
        .odd_q       (bank_q[1]),
        .odd_start_q (odd_start_q),
        .size_q      (size_q),
        .word        (rd_data)
    );

    assign rd_valid = valid_q;
endmodule

// File: rtl/hwf_fetch_mem_chk.sv
module hwf_fetch_mem_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          rd_size,
    input logic [31:0]   rd_data,
    input logic          rd_valid,
    input logic          wr_en
);
    // R5
    assert_valid_follows_read_R5: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    // R5
    assert_no_valid_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    // R4
    assert_half_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_size) |=> (rd_data[31:16] == 16'h0));
    // R6
    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    // R2: consecutive word reads at a and a+1 share a halfword
    assert_overlap_consistent_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_size && !wr_en) ##1
        (rd_en && rd_size && !wr_en && rd_addr == AW'($past(rd_addr) + 1'b1))
        |=> (rd_data[15:0] == $past(rd_data[31:16])));
    // R9
    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_data == 32'h0));
endmodule

bind hwf_fetch_mem hwf_fetch_mem_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_size  (rd_size),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .wr_en    (wr_en)
);

// File: tb/hwf_fetch_mem_tb.sv
`timescale 1ns/1ps
module hwf_fetch_mem_tb;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_size = 1'b0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] model [DEPTH];
    logic [31:0] last_exp = '0;

    always #4 clk = ~clk;

    hwf_fetch_mem #(.DEPTH_HW(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_data(rd_data), .rd_valid(rd_valid), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a, input logic sz);
        logic [AW-1:0] nxt;
        nxt = AW'(a + 1'b1);
        return sz ? {model[nxt], model[a]} : {16'h0, model[a]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge: drives one cycle of stimulus, checks the result
    // at the following negedge.
    task automatic op(input string req, input logic re, input logic [AW-1:0] ra,
                      input logic rs, input logic we, input logic [AW-1:0] wa,
                      input logic [15:0] wd);
        logic [31:0] exp;
        rd_en = re; rd_addr = ra; rd_size = rs;
        wr_en = we; wr_addr = wa; wr_data = wd;
        exp = re ? exp_word(ra, rs) : last_exp;
        if (we) model[wa] = wd;
        @(negedge clk);
        check(req, rd_data, exp);
        check({req, "_R5_valid"}, {31'h0, rd_valid}, {31'h0, re});
        last_exp = exp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R9: reset state while in reset, with a read requested
        rd_en = 1'b1;
        @(negedge clk);
        check("R9_in_reset", {rd_data[31:1], rd_valid}, 32'h0);
        check("R9_in_reset_data", rd_data, 32'h0);
        rd_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R9_after_reset", {31'h0, rd_valid}, 32'h0);
        check("R9_after_reset_data", rd_data, 32'h0);

        // R7: preload every halfword with a distinct value
        for (int i = 0; i < DEPTH; i++) begin
            op("R7_preload", 1'b0, '0, 1'b0, 1'b1, AW'(i), 16'(16'hA000 + i * 16'h0101));
        end

        op("R1_even_word", 1'b1, AW'(10), 1'b1, 1'b0, '0, '0);
        op("R2_odd_word", 1'b1, AW'(11), 1'b1, 1'b0, '0, '0);
        op("R2_odd_row_edge", 1'b1, AW'(127), 1'b1, 1'b0, '0, '0);
        op("R3_wrap_last", 1'b1, AW'(DEPTH-1), 1'b1, 1'b0, '0, '0);
        op("R4_half_even", 1'b1, AW'(4), 1'b0, 1'b0, '0, '0);
        op("R4_half_odd", 1'b1, AW'(DEPTH-1), 1'b0, 1'b0, '0, '0);
        op("R6_hold", 1'b0, AW'(20), 1'b1, 1'b0, '0, '0);
        op("R6_hold_with_write", 1'b0, AW'(DEPTH-1), 1'b1, 1'b1, AW'(DEPTH-1), 16'h1111);
        // R8: read sees old value on same-cycle collision (upper half too)
        begin
            logic [31:0] old;
            old = exp_word(AW'(DEPTH-2), 1'b1);
            rd_en = 1'b1; rd_addr = AW'(DEPTH-2); rd_size = 1'b1;
            wr_en = 1'b1; wr_addr = AW'(DEPTH-1); wr_data = 16'h2222;
            model[DEPTH-1] = 16'h2222;
            @(negedge clk);
            check("R8_collision_old", rd_data, old);
            last_exp = old;
        end
        op("R7_write_seen", 1'b1, AW'(DEPTH-2), 1'b1, 1'b0, '0, '0);
        op("R3_wrap_new_zero", 1'b1, AW'(0), 1'b1, 1'b1, AW'(0), 16'h3333);
        op("R3_wrap_after_write", 1'b1, AW'(DEPTH-1), 1'b1, 1'b0, '0, '0);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic re, rs, we;
            logic [AW-1:0] ra, wa;
            re = ($urandom % 4) != 0;
            rs = $urandom % 2;
            we = ($urandom % 3) == 0;
            ra = AW'($urandom);
            wa = (($urandom % 4) == 0) ? ra : AW'($urandom);
            op(rs ? "R2_random_word" : "R4_random_half", re, ra, rs, we, wa, 16'($urandom));
        end

        rd_en = 1'b0; wr_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule